// File: doc/BRIEF.md
# Character output port controller

This block lets a processor send text one character at a time to an output device over a simple register bus. It exposes two word registers: a status word holding a completion flag, an error flag and an interrupt enable, and a data word holding the character to send. Storing into the data word hands the byte to a sink through a valid/ready handshake. The port then counts as busy (completion flag clear) until the sink takes the byte, signals that it could not take it, or is found absent.

When a transfer finishes, the completion flag comes back on. The error flag records whether the last transfer failed, and an interrupt is requested if software has enabled one. The port comes out of reset already complete, so driver code may write its first character at once. A missing sink is reported through the error flag rather than by hanging the port. Interrupt arbitration and the device behind the sink are outside this block.

Top module: `chario_out`

## Requirements
- R1: After reset the status word reads with completion set, enable clear and error equal to the inverse of `sink_present_i`. The data word reads 0, and `irq_o` and `out_valid_o` are low.
- R2: Status word layout: error at bit 15, completion at bit 7, enable at bit 6, all other bits read 0. A full-word status store changes only the enable bit.
- R3: A status store with only the upper byte enabled (`be_i` = 2'b10) changes nothing.
- R4: Storing 0 in the enable bit drops `irq_o`. Storing 1 while enable was clear and completion or error is set raises `irq_o`.
- R5: A data store with `be_i[0]` set loads `wdata_i[7:0]`. A store with only `be_i[1]` set keeps the old character but still starts a transfer.
- R6: Any data store clears completion and drops `irq_o`. With a sink present, `out_valid_o` is high in the next cycle with `out_data_o` equal to the stored character.
- R7: `out_valid_o` and `out_data_o` hold until the sink raises `out_ready_i` or `out_fail_i`. On `out_ready_i` alone, completion is set, error is cleared and `out_valid_o` drops.
- R8: On `out_fail_i` the transfer ends with completion set and error set.
- R9: A data store while `sink_present_i` is low completes in the same cycle with error set and never raises `out_valid_o`.
- R10: A transfer that ends while enable is set raises `irq_o`. With enable clear, `irq_o` stays low.
- R11: Reading either register has no side effect on the flags or on `irq_o`.
- R12: If the sink disappears during a transfer, the transfer ends with error set, and the error stays set after the sink returns until a transfer succeeds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Byte address; bit 0 ignored |
| wr_i | input | 1 | Write strobe |
| be_i | input | 2 | Byte enables, bit 0 is the low byte |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for the addressed register, 0 if none |
| sink_present_i | input | 1 | Sink is connected |
| out_valid_o | output | 1 | Character offered to the sink |
| out_data_o | output | 8 | Character |
| out_ready_i | input | 1 | Sink accepts the character |
| out_fail_i | input | 1 | Sink rejects the character |
| irq_o | output | 1 | Interrupt request |

## Verification
On every cycle the assertions check that the offered character stays stable while the sink stalls, that a store with a sink present starts the handshake, and that an absent sink never sees a valid. They also check that a failed handshake ends the offer and that a request is never raised without enable. Only the bench's scenarios show the register-visible results: the reset image, ignored upper-byte status stores, character retention on upper-byte data stores, and the error flag persisting until a good transfer. The bench also compares `irq_o` and the handshake against its reference model every clock.

// File: rtl/chario_out_pkg.sv
package chario_out_pkg;
  localparam int REG_W    = 16;
  localparam int CHAR_W   = 8;
  localparam int ERR_BIT  = 15;
  localparam int DONE_BIT = 7;
  localparam int IE_BIT   = 6;
endpackage

// File: rtl/chario_out_decode.sv
module chario_out_decode #(
  parameter int              ADDR_W    = 22,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 22'o17777554,
  parameter logic [ADDR_W-1:0] BUF_ADDR  = 22'o17777556
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic [1:0]        be_i,
  output logic              stat_hit_o,
  output logic              buf_hit_o,
  output logic              stat_wr_o,
  output logic              buf_start_o,
  output logic              buf_load_o
);
  // word decode; byte lane chosen by be_i
  assign stat_hit_o  = addr_i[ADDR_W-1:1] == STAT_ADDR[ADDR_W-1:1];
  assign buf_hit_o   = addr_i[ADDR_W-1:1] == BUF_ADDR[ADDR_W-1:1];
  assign stat_wr_o   = wr_i && stat_hit_o && be_i[0];
  assign buf_start_o = wr_i && buf_hit_o && (be_i != 2'b00);
  assign buf_load_o  = wr_i && buf_hit_o && be_i[0];
endmodule

// File: rtl/chario_out_xfer.sv
module chario_out_xfer (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic present_i,
  input  logic ready_i,
  input  logic fail_i,
  output logic valid_o,
  output logic cmpl_o,
  output logic ok_o
);
  logic busy_q, busy_d, end_ev;

  assign end_ev = busy_q && (ready_i || fail_i || !present_i);

  always_comb begin
    // a new store restarts; absent sink finishes at once
    if (start_i) begin
      busy_d = present_i;
      cmpl_o = !present_i;
      ok_o   = 1'b0;
    end else begin
      busy_d = busy_q && !end_ev;
      cmpl_o = end_ev;
      ok_o   = end_ev && present_i && ready_i && !fail_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) busy_q <= 1'b0;
    else         busy_q <= busy_d;
  end

  assign valid_o = busy_q;
endmodule

// File: rtl/chario_out_flags.sv
module chario_out_flags #(
  parameter int CHAR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              present_i,
  input  logic              stat_wr_i,
  input  logic              ie_wdata_i,
  input  logic              buf_start_i,
  input  logic              buf_load_i,
  input  logic [CHAR_W-1:0] char_i,
  input  logic              cmpl_i,
  input  logic              ok_i,
  output logic              done_o,
  output logic              err_o,
  output logic              ie_o,
  output logic              irq_o,
  output logic [CHAR_W-1:0] char_o
);
  logic done_q, err_q, ie_q, irq_q;
  logic done_d, err_d, ie_d, irq_d;
  logic [CHAR_W-1:0] char_q, char_d;
  logic err_vis;

  assign err_vis = err_q || !present_i;

  always_comb begin
    done_d = done_q;
    err_d  = err_q;
    ie_d   = ie_q;
    irq_d  = irq_q;
    char_d = char_q;
    if (buf_load_i) char_d = char_i;
    if (buf_start_i) begin
      done_d = 1'b0;
      irq_d  = 1'b0;
    end
    if (cmpl_i) begin
      done_d = 1'b1;
      err_d  = !ok_i;
      if (ie_q) irq_d = 1'b1;
    end
    if (stat_wr_i) begin
      ie_d = ie_wdata_i;
      if (!ie_wdata_i) irq_d = 1'b0;
      else if (!ie_q && (done_q || err_vis)) irq_d = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q <= 1'b1;
      err_q  <= 1'b0;
      ie_q   <= 1'b0;
      irq_q  <= 1'b0;
      char_q <= '0;
    end else begin
      done_q <= done_d;
      err_q  <= err_d;
      ie_q   <= ie_d;
      irq_q  <= irq_d;
      char_q <= char_d;
    end
  end

  assign done_o = done_q;
  assign err_o  = err_vis;
  assign ie_o   = ie_q;
  assign irq_o  = irq_q;
  assign char_o = char_q;
endmodule

// File: rtl/chario_out.sv
module chario_out
  import chario_out_pkg::*;
#(
  parameter int                ADDR_W    = 22,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 22'o17777554,
  parameter logic [ADDR_W-1:0] BUF_ADDR  = 22'o17777556
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic [1:0]        be_i,
  input  logic [REG_W-1:0]  wdata_i,
  output logic [REG_W-1:0]  rdata_o,
  input  logic              sink_present_i,
  output logic              out_valid_o,
  output logic [CHAR_W-1:0] out_data_o,
  input  logic              out_ready_i,
  input  logic              out_fail_i,
  output logic              irq_o
);
  logic stat_hit, buf_hit, stat_wr, buf_start, buf_load;
  logic cmpl, ok, done_q, err_q, ie_q;
  logic [CHAR_W-1:0] char_q;
  logic unused_bits;

  assign unused_bits = ^{wdata_i[REG_W-1:CHAR_W], addr_i[0]};

  chario_out_decode #(
    .ADDR_W(ADDR_W), .STAT_ADDR(STAT_ADDR), .BUF_ADDR(BUF_ADDR)
  ) u_dec (
    .addr_i(addr_i), .wr_i(wr_i), .be_i(be_i),
    .stat_hit_o(stat_hit), .buf_hit_o(buf_hit), .stat_wr_o(stat_wr),
    .buf_start_o(buf_start), .buf_load_o(buf_load)
  );

  chario_out_xfer u_xfer (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(buf_start),
    .present_i(sink_present_i), .ready_i(out_ready_i), .fail_i(out_fail_i),
    .valid_o(out_valid_o), .cmpl_o(cmpl), .ok_o(ok)
  );

  chario_out_flags #(.CHAR_W(CHAR_W)) u_flags (
    .clk_i(clk_i), .rst_ni(rst_ni), .present_i(sink_present_i),
    .stat_wr_i(stat_wr), .ie_wdata_i(wdata_i[IE_BIT]),
    .buf_start_i(buf_start), .buf_load_i(buf_load), .char_i(wdata_i[CHAR_W-1:0]),
    .cmpl_i(cmpl), .ok_i(ok),
    .done_o(done_q), .err_o(err_q), .ie_o(ie_q), .irq_o(irq_o), .char_o(char_q)
  );

  always_comb begin
    rdata_o = '0;
    if (stat_hit) begin
      rdata_o[ERR_BIT]  = err_q;
      rdata_o[DONE_BIT] = done_q;
      rdata_o[IE_BIT]   = ie_q;
    end else if (buf_hit) begin
      rdata_o[CHAR_W-1:0] = char_q;
    end
  end

  assign out_data_o = char_q;
endmodule

// File: rtl/chario_out_chk.sv
module chario_out_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       wr_i,
  input logic       buf_hit_i,
  input logic [1:0] be_i,
  input logic       sink_present_i,
  input logic       out_valid_o,
  input logic [7:0] out_data_o,
  input logic       out_ready_i,
  input logic       out_fail_i,
  input logic       irq_o,
  input logic       ie_i
);
  logic store;
  assign store = wr_i && buf_hit_i && (be_i != 2'b00);

  a_r7_hold_while_stalled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i && !out_fail_i && sink_present_i && !store
    |=> out_valid_o && $stable(out_data_o));

  a_r6_store_starts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    store && sink_present_i |=> out_valid_o);

  a_r9_absent_no_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sink_present_i |=> !out_valid_o);

  a_r8_fail_ends: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && out_fail_i && !store |=> !out_valid_o);

  a_r10_irq_needs_ie: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> ie_i);
endmodule

bind chario_out chario_out_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(wr_i), .buf_hit_i(buf_hit), .be_i(be_i),
  .sink_present_i(sink_present_i), .out_valid_o(out_valid_o),
  .out_data_o(out_data_o), .out_ready_i(out_ready_i), .out_fail_i(out_fail_i),
  .irq_o(irq_o), .ie_i(ie_q)
);

// File: tb/chario_out_tb_top.sv
module chario_out_tb_top;
  localparam logic [21:0] STAT = 22'o17777554;
  localparam logic [21:0] BUFA = 22'o17777556;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic [21:0] addr_i = STAT;
  logic wr_i = 1'b0;
  logic [1:0] be_i = 2'b00;
  logic [15:0] wdata_i = '0;
  logic [15:0] rdata_o;
  logic sink_present_i = 1'b1;
  logic out_valid_o;
  logic [7:0] out_data_o;
  logic out_ready_i = 1'b0;
  logic out_fail_i = 1'b0;
  logic irq_o;

  int checks = 0;
  int errors = 0;

  always #2.5 clk_i = ~clk_i;

  chario_out dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .wr_i(wr_i), .be_i(be_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .sink_present_i(sink_present_i),
    .out_valid_o(out_valid_o), .out_data_o(out_data_o),
    .out_ready_i(out_ready_i), .out_fail_i(out_fail_i), .irq_o(irq_o)
  );

  // reference model
  bit m_done, m_err, m_ie, m_irq, m_busy;
  bit [7:0] m_char;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_done = 1; m_err = 0; m_ie = 0; m_irq = 0; m_busy = 0; m_char = 0;
    end else begin
      bit sw, bw, fin, good, pre_ie, pre_done, pre_err;
      sw = wr_i && addr_i == STAT && be_i[0];
      bw = wr_i && addr_i == BUFA && be_i != 0;
      pre_ie = m_ie; pre_done = m_done; pre_err = m_err || !sink_present_i;
      fin = 0; good = 0;
      if (bw) begin
        if (be_i[0]) m_char = wdata_i[7:0];
        m_done = 0; m_irq = 0;
        m_busy = sink_present_i;
        fin = !sink_present_i;
      end else if (m_busy && (out_ready_i || out_fail_i || !sink_present_i)) begin
        fin = 1; m_busy = 0;
        good = out_ready_i && !out_fail_i && sink_present_i;
      end
      if (fin) begin
        m_done = 1; m_err = !good;
        if (pre_ie) m_irq = 1;
      end
      if (sw) begin
        if (!wdata_i[6]) m_irq = 0;
        else if (!pre_ie && (pre_done || pre_err)) m_irq = 1;
        m_ie = wdata_i[6];
      end
    end
  end

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // per-cycle compare against the model (R6, R7, R10)
  always @(posedge clk_i) begin
    #1;
    if (rst_ni) begin
      check("R10 irq per cycle", {15'b0, irq_o}, {15'b0, m_irq});
      check("R7 valid per cycle", {15'b0, out_valid_o}, {15'b0, m_busy});
      if (m_busy) check("R6 data per cycle", {8'b0, out_data_o}, {8'b0, m_char});
    end
  end

  task automatic bus_wr(input logic [21:0] a, input logic [1:0] be, input logic [15:0] d);
    @(negedge clk_i);
    addr_i = a; be_i = be; wdata_i = d; wr_i = 1'b1;
    @(negedge clk_i);
    wr_i = 1'b0; be_i = 2'b00;
  endtask

  task automatic rd(input logic [21:0] a, input string tag, input logic [15:0] exp);
    addr_i = a;
    #0.5;
    check(tag, rdata_o, exp);
  endtask

  task automatic sink_pulse(input logic rdy, input logic fl);
    out_ready_i = rdy; out_fail_i = fl;
    @(negedge clk_i);
    out_ready_i = 1'b0; out_fail_i = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1 reset image
    rd(STAT, "R1 status after reset", 16'h0080);
    rd(BUFA, "R1 buffer after reset", 16'h0000);
    check("R1 irq low", {15'b0, irq_o}, 16'h0);
    check("R1 valid low", {15'b0, out_valid_o}, 16'h0);
    // R2 only enable writable; R4 enable rising with done raises irq
    bus_wr(STAT, 2'b11, 16'hFFFF);
    rd(STAT, "R2 status after all-ones store", 16'h00C0);
    check("R4 irq on enable rise", {15'b0, irq_o}, 16'h1);
    bus_wr(STAT, 2'b11, 16'h0000);
    rd(STAT, "R2 status after zero store", 16'h0080);
    check("R4 irq drop on enable clear", {15'b0, irq_o}, 16'h0);
    // R3 upper-byte status store ignored
    bus_wr(STAT, 2'b10, 16'hFFFF);
    rd(STAT, "R3 upper-byte status store", 16'h0080);
    check("R3 irq unchanged", {15'b0, irq_o}, 16'h0);
    // R5/R6/R7/R10 good transfer with enable set
    bus_wr(STAT, 2'b01, 16'h0040);
    bus_wr(BUFA, 2'b11, 16'h01A5);
    rd(BUFA, "R5 low byte loaded", 16'h00A5);
    rd(STAT, "R6 done cleared", 16'h0040);
    check("R6 irq dropped", {15'b0, irq_o}, 16'h0);
    check("R6 valid raised", {15'b0, out_valid_o}, 16'h1);
    check("R6 data offered", {8'b0, out_data_o}, 16'h00A5);
    repeat (3) @(negedge clk_i);
    check("R7 valid held", {15'b0, out_valid_o}, 16'h1);
    sink_pulse(1'b1, 1'b0);
    rd(STAT, "R7 good completion", 16'h00C0);
    check("R7 valid dropped", {15'b0, out_valid_o}, 16'h0);
    check("R10 irq on completion", {15'b0, irq_o}, 16'h1);
    // R5 upper-byte data store keeps char; R8 fail
    bus_wr(BUFA, 2'b10, 16'h3C00);
    rd(BUFA, "R5 upper-byte store keeps char", 16'h00A5);
    check("R5 upper-byte store starts", {15'b0, out_valid_o}, 16'h1);
    @(negedge clk_i);
    sink_pulse(1'b0, 1'b1);
    rd(STAT, "R8 fail sets error", 16'h80C0);
    // R7 success clears error
    bus_wr(BUFA, 2'b01, 16'h0042);
    sink_pulse(1'b1, 1'b0);
    rd(STAT, "R7 success clears error", 16'h00C0);
    // R9 absent sink, enable off (R10)
    bus_wr(STAT, 2'b01, 16'h0000);
    sink_present_i = 1'b0;
    @(negedge clk_i);
    rd(STAT, "R9 absent shows error", 16'h8080);
    bus_wr(BUFA, 2'b01, 16'h0011);
    rd(STAT, "R9 immediate error completion", 16'h8080);
    check("R9 no valid", {15'b0, out_valid_o}, 16'h0);
    check("R10 no irq with enable clear", {15'b0, irq_o}, 16'h0);
    bus_wr(STAT, 2'b01, 16'h0040);
    check("R4 irq on enable rise with error", {15'b0, irq_o}, 16'h1);
    // R12 sink lost mid-transfer
    sink_present_i = 1'b1;
    bus_wr(BUFA, 2'b01, 16'h0077);
    check("R12 transfer started", {15'b0, out_valid_o}, 16'h1);
    sink_present_i = 1'b0;
    @(negedge clk_i);
    sink_present_i = 1'b1;
    @(negedge clk_i);
    rd(STAT, "R12 error persists after sink returns", 16'h80C0);
    check("R12 irq on aborted completion", {15'b0, irq_o}, 16'h1);
    // R11 reads have no side effects
    rd(BUFA, "R11 buffer read", 16'h0077);
    @(negedge clk_i);
    rd(BUFA, "R11 buffer read again", 16'h0077);
    @(negedge clk_i);
    rd(STAT, "R11 status unchanged", 16'h80C0);
    check("R11 irq unchanged", {15'b0, irq_o}, 16'h1);
    repeat (2) @(negedge clk_i);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule